// File: doc/BRIEF.md
# Fine-Grained Multithread Issue Selector

This block chooses, in every clock cycle, which of four hardware thread contexts hands its next instruction to a single-issue, in-order pipeline. It keeps, for each thread, a registered enable bit, a short countdown that follows a load or a branch, and a flag for an open cache miss. A thread may be chosen only when it is enabled, its countdown is zero and it has no miss open. The choice rotates: the search starts at the thread after the one that issued last, and it skips every thread that may not be chosen. The latency of loads, branches and misses is therefore hidden behind the other threads. No instruction goes out only when no thread may be chosen.

The pipeline reports the kind of the instruction that issues (load, branch or other) in the same cycle as the grant. The memory side sends separate pulses, each carrying a thread number, when a miss opens and when it closes. The per-thread enable inputs are sampled into registers, so a change reaches the selection one cycle later.

Top module: `mt_issue_sel`

## Requirements
- R1: A synchronous reset clears all enable registers, countdowns and miss flags and points the rotation at thread 0. `sel_valid_o` is 0 during reset and in the first cycle after it.
- R2: A thread whose enable input was 0 at the previous clock edge is never selected, whatever its stall state.
- R3: The search starts at the thread after the last one that issued, wrapping from 3 to 0. After reset it starts at thread 0. The grant goes to the first thread in that order that may issue.
- R4: An issue of kind load (code 1) or branch (code 2) makes that thread ineligible for the next 3 cycles. It may issue again in the 4th cycle.
- R5: An issue of kind other (code 0) or of the spare code 3 leaves the thread eligible in the next cycle.
- R6: A miss-open pulse for thread n makes n ineligible from the next cycle. It stays ineligible through the cycle of the matching miss-close pulse and may issue from the cycle after it.
- R7: When a miss and a load/branch countdown overlap, the thread stays ineligible until both have ended.
- R8: `sel_valid_o` is 0 exactly when no thread may issue. `sel_id_o` is then 0.
- R9: A miss-close pulse for a thread that has no miss open has no effect. If open and close arrive for the same thread in the same cycle, the open wins.
- R10: `issue_kind_i` is ignored in a cycle where `sel_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| thr_valid_i | input | NUM_THR | Per-thread enable, sampled every edge |
| issue_kind_i | input | 2 | Kind of the instruction issued this cycle: 0 other, 1 load, 2 branch, 3 spare |
| miss_set_i | input | 1 | Miss-open pulse |
| miss_set_id_i | input | ID_W | Thread number for the miss-open pulse |
| miss_clr_i | input | 1 | Miss-close pulse |
| miss_clr_id_i | input | ID_W | Thread number for the miss-close pulse |
| sel_id_o | output | ID_W | Thread granted this cycle |
| sel_valid_o | output | 1 | An instruction issues this cycle |

## Verification
The grant depends only on registered state, so a wrong countdown, miss flag or rotation pointer shows at the ports in the very next cycle. Depending on the fault, the thread number is wrong, a stalled thread is chosen, or `sel_valid_o` drops while a ready thread waits. A countdown that is one cycle off shows up as the thread coming back one cycle early or late. A miss flag that leaks or sticks shows up as a thread that never returns, or one that returns before its close pulse. The bench keeps its own model of each thread's state and compares both outputs in every cycle, so any such drift is caught within one cycle of its first visible effect.

// File: rtl/mt_sel_pkg.sv
package mt_sel_pkg;

   typedef enum logic [1:0] {
      KIND_OTHER  = 2'd0,
      KIND_LOAD   = 2'd1,
      KIND_BRANCH = 2'd2,
      KIND_SPARE  = 2'd3
   } issue_kind_e;

   // Kinds that open a fixed-length issue shadow on the issuing thread.
   function automatic logic kind_opens_shadow(input issue_kind_e k);
      return (k == KIND_LOAD) || (k == KIND_BRANCH);
   endfunction

endpackage

// File: rtl/mt_thread_ctx.sv
module mt_thread_ctx #(
   parameter int SHADOW_CYC = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic valid_i,
   input  logic shadow_start_i,
   input  logic miss_open_i,
   input  logic miss_close_i,
   output logic valid_o,
   output logic elig_o
);
   localparam int CNT_W = (SHADOW_CYC < 1) ? 1 : $clog2(SHADOW_CYC + 1);

   logic valid_q;
   logic miss_q;
   logic shadow_done;

   always_ff @(posedge clk) begin
      if (rst) valid_q <= 1'b0;
      else     valid_q <= valid_i;
   end

   // Open beats close when both hit in the same cycle (R9).
   always_ff @(posedge clk) begin
      if (rst)               miss_q <= 1'b0;
      else if (miss_open_i)  miss_q <= 1'b1;
      else if (miss_close_i) miss_q <= 1'b0;
   end

   generate
      if (SHADOW_CYC == 0) begin : g_no_shadow
         assign shadow_done = 1'b1;
      end else begin : g_shadow
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst)                 cnt_q <= '0;
            else if (shadow_start_i) cnt_q <= CNT_W'(SHADOW_CYC);
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end

         assign shadow_done = (cnt_q == '0);

         p_shadow_start_r4: assert property (@(posedge clk) disable iff (rst)
            shadow_start_i |=> !elig_o);

         p_shadow_expire_r4: assert property (@(posedge clk) disable iff (rst)
            (cnt_q == CNT_W'(1) && !miss_q && !miss_open_i && valid_i) |=> elig_o);
      end
   endgenerate

   assign valid_o = valid_q;
   assign elig_o  = valid_q && shadow_done && !miss_q;

   p_miss_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (miss_q && !miss_close_i) |=> !elig_o);

   p_miss_open_r6: assert property (@(posedge clk) disable iff (rst)
      miss_open_i |=> !elig_o);

   p_disabled_idle_r2: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> !elig_o);

endmodule

// File: rtl/mt_rr_pick.sv
module mt_rr_pick #(
   parameter int N = 4,
   localparam int ID_W = (N < 2) ? 1 : $clog2(N)
) (
   input  logic [N-1:0]    elig_i,
   input  logic [ID_W-1:0] ptr_i,
   output logic            gnt_valid_o,
   output logic [ID_W-1:0] gnt_id_o
);
   logic [ID_W:0]   sum;
   logic [ID_W-1:0] idx;

   always_comb begin
      gnt_valid_o = 1'b0;
      gnt_id_o    = '0;
      sum         = '0;
      idx         = '0;
      for (int k = 0; k < N; k++) begin
         sum = {1'b0, ptr_i} + (ID_W+1)'(k);
         if (sum >= (ID_W+1)'(N)) sum = sum - (ID_W+1)'(N);
         idx = sum[ID_W-1:0];
         if (!gnt_valid_o && elig_i[idx]) begin
            gnt_valid_o = 1'b1;
            gnt_id_o    = idx;
         end
      end
   end

endmodule

// File: rtl/mt_issue_sel.sv
module mt_issue_sel
   import mt_sel_pkg::*;
#(
   parameter int NUM_THR    = 4,
   parameter int SHADOW_CYC = 3,
   localparam int ID_W = (NUM_THR < 2) ? 1 : $clog2(NUM_THR)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_THR-1:0] thr_valid_i,
   input  logic [1:0]         issue_kind_i,
   input  logic               miss_set_i,
   input  logic [ID_W-1:0]    miss_set_id_i,
   input  logic               miss_clr_i,
   input  logic [ID_W-1:0]    miss_clr_id_i,
   output logic [ID_W-1:0]    sel_id_o,
   output logic               sel_valid_o
);
   generate
      if (NUM_THR < 2 || NUM_THR > 64) begin : g_bad_thr
         $error("mt_issue_sel: NUM_THR must lie in 2..64");
      end
      if (SHADOW_CYC < 0 || SHADOW_CYC > 15) begin : g_bad_shadow
         $error("mt_issue_sel: SHADOW_CYC must lie in 0..15");
      end
   endgenerate

   logic [NUM_THR-1:0] elig;
   logic [NUM_THR-1:0] thr_vld;
   logic [ID_W-1:0]    ptr_q;
   logic               gnt_valid;
   logic [ID_W-1:0]    gnt_id;
   logic               opens_shadow;

   assign opens_shadow = kind_opens_shadow(issue_kind_e'(issue_kind_i));

   generate
      for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
         logic start_t, open_t, close_t;
         assign start_t = gnt_valid && (gnt_id == ID_W'(t)) && opens_shadow;
         assign open_t  = miss_set_i && (miss_set_id_i == ID_W'(t));
         assign close_t = miss_clr_i && (miss_clr_id_i == ID_W'(t));

         mt_thread_ctx #(.SHADOW_CYC(SHADOW_CYC)) ctx_i (
            .clk            (clk),
            .rst            (rst),
            .valid_i        (thr_valid_i[t]),
            .shadow_start_i (start_t),
            .miss_open_i    (open_t),
            .miss_close_i   (close_t),
            .valid_o        (thr_vld[t]),
            .elig_o         (elig[t])
         );
      end
   endgenerate

   mt_rr_pick #(.N(NUM_THR)) pick_i (
      .elig_i      (elig),
      .ptr_i       (ptr_q),
      .gnt_valid_o (gnt_valid),
      .gnt_id_o    (gnt_id)
   );

   always_ff @(posedge clk) begin
      if (rst)            ptr_q <= '0;
      else if (gnt_valid) ptr_q <= (gnt_id == ID_W'(NUM_THR-1)) ? '0 : gnt_id + 1'b1;
   end

   assign sel_valid_o = gnt_valid;
   assign sel_id_o    = gnt_id;

   p_grant_enabled_r2: assert property (@(posedge clk) disable iff (rst)
      sel_valid_o |-> thr_vld[sel_id_o]);

   p_grant_eligible_r8: assert property (@(posedge clk) disable iff (rst)
      sel_valid_o |-> elig[sel_id_o]);

   p_idle_only_when_none_r8: assert property (@(posedge clk) disable iff (rst)
      !sel_valid_o |-> (elig == '0 && sel_id_o == '0));

   p_repeat_only_alone_r3: assert property (@(posedge clk) disable iff (rst)
      (sel_valid_o && $past(sel_valid_o) && sel_id_o == $past(sel_id_o))
         |-> $countones(elig) == 1);

   p_first_after_reset_r1: assert property (@(posedge clk)
      $fell(rst) |-> !sel_valid_o);

endmodule

// File: tb/mt_issue_sel_tb.sv
`timescale 1ns/1ps
module mt_issue_sel_tb_top;
   localparam int NT = 4;
   localparam int SH = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NT-1:0] thr_valid = '0;
   logic [1:0]    kind = 2'd0;
   logic          mset = 1'b0, mclr = 1'b0;
   logic [1:0]    mset_id = '0, mclr_id = '0;
   logic [1:0]    sel_id;
   logic          sel_valid;

   int checks = 0;
   int fails  = 0;

   // Reference state, built from the requirements.
   bit  m_vld  [NT];
   int  m_cnt  [NT];
   bit  m_miss [NT];
   int  m_ptr;

   always #10 clk = ~clk;

   mt_issue_sel #(.NUM_THR(NT), .SHADOW_CYC(SH)) dut_i (
      .clk(clk), .rst(rst), .thr_valid_i(thr_valid), .issue_kind_i(kind),
      .miss_set_i(mset), .miss_set_id_i(mset_id),
      .miss_clr_i(mclr), .miss_clr_id_i(mclr_id),
      .sel_id_o(sel_id), .sel_valid_o(sel_valid));

   task automatic chk(input string tag, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int t = 0; t < NT; t++) begin m_vld[t] = 0; m_cnt[t] = 0; m_miss[t] = 0; end
      m_ptr = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1; thr_valid = '0;
      kind = 0; mset = 0; mclr = 0;
      @(negedge clk); #1;
      chk("R1", sel_valid, 0, "sel_valid in reset");
      @(negedge clk); #1;
      chk("R1", sel_valid, 0, "sel_valid in reset");
      model_reset();
   endtask

   // One cycle: drive at negedge, compare, then advance the model past the next edge.
   task automatic step(input string tag, input logic [NT-1:0] v, input logic [1:0] k,
                       input bit ms, input int msid, input bit mc, input int mcid);
      bit e_ok; int e_id; bit el;
      @(negedge clk);
      rst = 1'b0; thr_valid = v; kind = k;
      mset = ms; mset_id = 2'(msid); mclr = mc; mclr_id = 2'(mcid);
      #1;
      e_ok = 0; e_id = 0;
      for (int o = 0; o < NT; o++) begin
         int i = (m_ptr + o) % NT;
         el = m_vld[i] && m_cnt[i] == 0 && !m_miss[i];
         if (!e_ok && el) begin e_ok = 1; e_id = i; end
      end
      chk(tag, sel_valid, e_ok, "sel_valid");
      chk(tag, sel_id, e_id, "sel_id");
      for (int t = 0; t < NT; t++) begin
         if (e_ok && e_id == t && (k == 2'd1 || k == 2'd2)) m_cnt[t] = SH;
         else if (m_cnt[t] > 0) m_cnt[t]--;
         if (ms && msid == t) m_miss[t] = 1;
         else if (mc && mcid == t) m_miss[t] = 0;
         m_vld[t] = v[t];
      end
      if (e_ok) m_ptr = (e_id + 1) % NT;
   endtask

   task automatic expect_now(input string tag, input int ok, input int id);
      // Explicit look at the outputs of the cycle following the last step.
      @(negedge clk); #1;
      chk(tag, sel_valid, ok, "sel_valid direct");
      if (ok != 0) chk(tag, sel_id, id, "sel_id direct");
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      model_reset();
      do_reset();
      // R1: first cycle after reset is idle even with all enables high.
      step("R1", 4'hF, 0, 0, 0, 0, 0);
      // R3: plain rotation 0,1,2,3,0,...
      for (int n = 0; n < 9; n++) step("R3", 4'hF, 0, 0, 0, 0, 0);
      // R2: only threads 1 and 3 enabled
      for (int n = 0; n < 7; n++) step("R2", 4'b1010, 0, 0, 0, 0, 0);
      // R4/R8: single thread, load then branch
      do_reset();
      step("R4", 4'b0001, 0, 0, 0, 0, 0);
      step("R4", 4'b0001, 2'd1, 0, 0, 0, 0);      // thread 0 issues a load
      for (int n = 0; n < 4; n++) step("R8", 4'b0001, 0, 0, 0, 0, 0);
      step("R4", 4'b0001, 2'd2, 0, 0, 0, 0);      // branch
      for (int n = 0; n < 4; n++) step("R4", 4'b0001, 0, 0, 0, 0, 0);
      // R5: spare and other kinds do not stall
      for (int n = 0; n < 4; n++) step("R5", 4'b0001, 2'd3, 0, 0, 0, 0);
      // R6: miss on thread 0 held until close
      step("R6", 4'b0001, 0, 1, 0, 0, 0);
      for (int n = 0; n < 5; n++) step("R6", 4'b0001, 0, 0, 0, 0, 0);
      step("R6", 4'b0001, 0, 0, 0, 1, 0);
      for (int n = 0; n < 2; n++) step("R6", 4'b0001, 0, 0, 0, 0, 0);
      // R9: stray close, then open+close together
      step("R9", 4'b0001, 0, 0, 0, 1, 0);
      step("R9", 4'b0001, 0, 1, 0, 1, 0);
      for (int n = 0; n < 3; n++) step("R9", 4'b0001, 0, 0, 0, 0, 0);
      // R10: load kind while idle must not open a shadow
      step("R10", 4'b0001, 2'd1, 0, 0, 1, 0);
      expect_now("R10", 1, 0);
      // R7: overlap, load then miss closing early, then miss outlasting shadow
      do_reset();
      step("R7", 4'b0100, 0, 0, 0, 0, 0);
      step("R7", 4'b0100, 2'd1, 1, 2, 0, 0);
      step("R7", 4'b0100, 0, 0, 0, 1, 2);
      for (int n = 0; n < 4; n++) step("R7", 4'b0100, 0, 0, 0, 0, 0);
      step("R7", 4'b0100, 2'd2, 1, 2, 0, 0);
      for (int n = 0; n < 5; n++) step("R7", 4'b0100, 0, 0, 0, 0, 0);
      step("R7", 4'b0100, 0, 0, 0, 1, 2);
      for (int n = 0; n < 2; n++) step("R7", 4'b0100, 0, 0, 0, 0, 0);
      // Broad sweep over mixed stimulus (R3 rotation with skips)
      do_reset();
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] r = $urandom;
         logic [NT-1:0] v = (r[3:0] == 4'd0) ? r[7:4] : 4'hF;
         step("R3", v, r[9:8], r[13:10] == 4'd0, int'(r[15:14]),
              r[18:16] < 3'd3, int'(r[20:19]));
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule